// File: doc/BRIEF.md
# Host Bus Style Detector and Interrupt Vector Source

This block sits at the parallel host port of a serial-bus controller. It works out which kind of host bus is attached. One kind has separate read and write strobes. The other has a single read/write line and expects a data-acknowledge reply. The block does not read a strapping pin for this. It watches the first write strobe edge and the state of chip select at that edge. After that first edge the choice is locked until the next reset.

When the read/write-line style is active, the block drives the active-low data-acknowledge output and enables its driver. In both styles it drives an active-low interrupt request from the interrupt-enable bit and the pending-interrupt flag. During an interrupt-acknowledge cycle it also supplies an 8-bit vector. If the host has never written the vector register, the vector returns a default that depends on the detected style. Once the host writes the register, the written value is used instead.

Top module: `hbm_host_port`

## Requirements
- R1: After reset the block is in separate-strobe style: `style_rw`=0, `dtack_oe`=0, `dtack_n`=1.
- R2: A clock edge that samples `wr_n` low, where the previous edge sampled it high, while `cs_n` is high, switches the block to read/write-line style (`style_rw`=1, `dtack_oe`=1) after that edge. This applies only if no style has been locked yet.
- R3: If the first falling `wr_n` edge is sampled with `cs_n` low, the block locks into separate-strobe style. A later falling `wr_n` edge with `cs_n` high then has no effect.
- R4: Once in read/write-line style, the block stays there until reset, whatever `wr_n` and `cs_n` do.
- R5: In read/write-line style, `dtack_n` goes low after the first clock edge that samples `cs_n` low. It returns high in the same cycle that `cs_n` goes high. In separate-strobe style `dtack_n` stays 1.
- R6: `vec_oe`=1 and `vec_out` carries the vector only while `iack_n`=0 and `irq_en`=1. Otherwise `vec_oe`=0 and `vec_out`=00h.
- R7: While the vector register has not been written since reset, the vector is 00h in separate-strobe style and 0Fh in read/write-line style.
- R8: A clock edge with `vec_we`=1 loads `vec_wdata`. From the next cycle on, that value is the vector in either style.
- R9: `irq_n` is 0 exactly when `irq_en`=1 and `pend_n`=0. It does not depend on the clock.
- R10: Reset clears the vector register to 00h and drops any earlier host write, so the style default applies again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Host chip select, active low |
| wr_n | input | 1 | Write strobe, or read/write line in the read/write-line style |
| iack_n | input | 1 | Interrupt acknowledge, active low |
| irq_en | input | 1 | Interrupt enable bit |
| pend_n | input | 1 | Pending-interrupt flag, 0 = pending |
| vec_we | input | 1 | Vector register write enable |
| vec_wdata | input | 8 | Vector register write data |
| style_rw | output | 1 | 1 = read/write-line style detected |
| dtack_oe | output | 1 | Data-acknowledge driver enable |
| dtack_n | output | 1 | Data acknowledge, active low |
| irq_n | output | 1 | Interrupt request, active low |
| vec_oe | output | 1 | Vector drive enable toward the data bus |
| vec_out | output | 8 | Interrupt vector |

## Verification
Style detection and vector writes take effect one clock edge after the sampled stimulus. The bench therefore drives inputs on the falling edge and reads these results two time units after the next rising edge. The assertion edge of `dtack_n` follows the same rule. Its release, `irq_n`, `vec_oe` and `vec_out` are combinational, so they are read one time unit after the input change, with no clock edge in between. Where no change is expected, the bench samples both before and after an edge to show that nothing moved.

// File: rtl/hbm_pkg.sv
package hbm_pkg;
    typedef enum logic {
        STYLE_SEP = 1'b0,
        STYLE_RW  = 1'b1
    } bus_style_e;
endpackage

// File: rtl/hbm_style_detect.sv
module hbm_style_detect
    import hbm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       wr_n,
    output bus_style_e style_o,
    output logic       dtack_n_o
);
    typedef struct packed {
        logic       wr_prev;
        logic       locked;
        bus_style_e style;
        logic       dtack;
    } det_state_t;

    det_state_t st_d, st_q;
    logic       wr_fall;

    always_comb begin
        st_d         = st_q;
        wr_fall      = st_q.wr_prev & ~wr_n;
        st_d.wr_prev = wr_n;
        if (!st_q.locked && wr_fall) begin
            st_d.locked = 1'b1;
            st_d.style  = cs_n ? STYLE_RW : STYLE_SEP;
        end
        st_d.dtack = (st_q.style == STYLE_RW) & ~cs_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{wr_prev: 1'b1, locked: 1'b0, style: STYLE_SEP, dtack: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign style_o   = st_q.style;
    assign dtack_n_o = ~(st_q.dtack & ~cs_n);

    // R4
    rw_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.style == STYLE_RW) |=> (st_q.style == STYLE_RW));
    // R3
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.locked |=> $stable(st_q.style));
    // R5
    dtack_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.style == STYLE_RW) && !cs_n) |=> (cs_n || !dtack_n_o));
    // R5
    dtack_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.style == STYLE_SEP) |-> dtack_n_o);
endmodule

// File: rtl/hbm_vector_reg.sv
module hbm_vector_reg
    import hbm_pkg::*;
#(
    parameter int                VEC_W      = 8,
    parameter logic [VEC_W-1:0]  DEF_SEP    = '0,
    parameter logic [VEC_W-1:0]  DEF_RW     = VEC_W'(8'h0F)
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [VEC_W-1:0] wdata,
    input  bus_style_e       style,
    output logic [VEC_W-1:0] vec_o
);
    typedef struct packed {
        logic             written;
        logic [VEC_W-1:0] value;
    } vec_state_t;

    vec_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.written = 1'b1;
            st_d.value   = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        if (st_q.written) begin
            vec_o = st_q.value;
        end else if (style == STYLE_RW) begin
            vec_o = DEF_RW;
        end else begin
            vec_o = DEF_SEP;
        end
    end

    // R8
    vec_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (vec_o == $past(wdata)));
endmodule

// File: rtl/hbm_host_port.sv
module hbm_host_port
    import hbm_pkg::*;
#(
    parameter int VEC_W = 8
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             wr_n,
    input  logic             iack_n,
    input  logic             irq_en,
    input  logic             pend_n,
    input  logic             vec_we,
    input  logic [VEC_W-1:0] vec_wdata,
    output logic             style_rw,
    output logic             dtack_oe,
    output logic             dtack_n,
    output logic             irq_n,
    output logic             vec_oe,
    output logic [VEC_W-1:0] vec_out
);
    bus_style_e       style;
    logic [VEC_W-1:0] vec_cur;

    hbm_style_detect u_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .wr_n      (wr_n),
        .style_o   (style),
        .dtack_n_o (dtack_n)
    );

    hbm_vector_reg #(.VEC_W(VEC_W)) u_vector (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (vec_we),
        .wdata (vec_wdata),
        .style (style),
        .vec_o (vec_cur)
    );

    always_comb begin
        style_rw = (style == STYLE_RW);
        dtack_oe = style_rw;
        irq_n    = ~(irq_en & ~pend_n);
        vec_oe   = irq_en & ~iack_n;
        vec_out  = vec_oe ? vec_cur : '0;
    end

    // R9
    irq_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en && !pend_n) |-> !irq_n);
    // R6
    vec_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_oe |-> (vec_out == '0));
    // R2
    oe_style_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dtack_oe |-> style_rw);
endmodule

// File: tb/hbm_host_port_bench.sv
module hbm_host_port_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n, cs_n, wr_n, iack_n, irq_en, pend_n, vec_we;
    logic [7:0] vec_wdata;
    logic       style_rw, dtack_oe, dtack_n, irq_n, vec_oe;
    logic [7:0] vec_out;
    int         n_chk = 0;
    int         n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hbm_host_port u_hbm_host_port (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .iack_n(iack_n),
        .irq_en(irq_en), .pend_n(pend_n), .vec_we(vec_we), .vec_wdata(vec_wdata),
        .style_rw(style_rw), .dtack_oe(dtack_oe), .dtack_n(dtack_n),
        .irq_n(irq_n), .vec_oe(vec_oe), .vec_out(vec_out)
    );

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic edge_then_sample();
        @(posedge clk);
        #2;
    endtask

    task automatic drive_at_neg();
        @(negedge clk);
    endtask

    task automatic do_reset();
        drive_at_neg();
        rst_n = 1'b0; cs_n = 1'b1; wr_n = 1'b1; iack_n = 1'b1;
        irq_en = 1'b0; pend_n = 1'b1; vec_we = 1'b0; vec_wdata = 8'h00;
        edge_then_sample();
        drive_at_neg();
        rst_n = 1'b1;
        edge_then_sample();
    endtask

    task automatic t_reset_state();
        do_reset();
        chk("R1 style", {7'd0, style_rw}, 8'd0);
        chk("R1 dtack_oe", {7'd0, dtack_oe}, 8'd0);
        chk("R1 dtack_n", {7'd0, dtack_n}, 8'd1);
    endtask

    task automatic t_irq();
        for (int i = 0; i < 4; i++) begin
            drive_at_neg();
            irq_en = i[1]; pend_n = i[0];
            #1;
            chk("R9 irq_n", {7'd0, irq_n}, {7'd0, ~(i[1] & ~i[0])});
        end
        pend_n = 1'b1;
    endtask

    task automatic t_vec_gate_sep();
        drive_at_neg();
        irq_en = 1'b1; iack_n = 1'b0;
        #1;
        chk("R6 vec_oe on", {7'd0, vec_oe}, 8'd1);
        chk("R7 default sep", vec_out, 8'h00);
        irq_en = 1'b0;
        #1;
        chk("R6 vec_oe off en", {7'd0, vec_oe}, 8'd0);
        irq_en = 1'b1; iack_n = 1'b1;
        #1;
        chk("R6 vec_oe off iack", {7'd0, vec_oe}, 8'd0);
    endtask

    task automatic t_vec_write_sep();
        drive_at_neg();
        vec_we = 1'b1; vec_wdata = 8'hA5;
        edge_then_sample();
        drive_at_neg();
        vec_we = 1'b0; iack_n = 1'b0;
        #1;
        chk("R8 written sep", vec_out, 8'hA5);
        iack_n = 1'b1;
        #1;
        chk("R6 hidden", vec_out, 8'h00);
    endtask

    task automatic t_lock_sep();
        do_reset();
        drive_at_neg();
        cs_n = 1'b0; wr_n = 1'b0;
        edge_then_sample();
        drive_at_neg();
        wr_n = 1'b1;
        edge_then_sample();
        drive_at_neg();
        cs_n = 1'b1;
        edge_then_sample();
        drive_at_neg();
        wr_n = 1'b0;
        edge_then_sample();
        edge_then_sample();
        chk("R3 locked sep", {7'd0, style_rw}, 8'd0);
        drive_at_neg();
        wr_n = 1'b1; cs_n = 1'b0;
        edge_then_sample();
        chk("R5 no dtack sep", {7'd0, dtack_n}, 8'd1);
        cs_n = 1'b1;
    endtask

    task automatic t_rw_style();
        do_reset();
        drive_at_neg();
        wr_n = 1'b0;
        #1;
        chk("R2 not before edge", {7'd0, style_rw}, 8'd0);
        edge_then_sample();
        chk("R2 style rw", {7'd0, style_rw}, 8'd1);
        chk("R2 dtack_oe", {7'd0, dtack_oe}, 8'd1);
        drive_at_neg();
        wr_n = 1'b1; irq_en = 1'b1; iack_n = 1'b0;
        #1;
        chk("R7 default rw", vec_out, 8'h0F);
        iack_n = 1'b1;
        cs_n = 1'b0;
        #1;
        chk("R5 dtack before edge", {7'd0, dtack_n}, 8'd1);
        edge_then_sample();
        chk("R5 dtack asserted", {7'd0, dtack_n}, 8'd0);
        drive_at_neg();
        cs_n = 1'b1;
        #1;
        chk("R5 dtack released", {7'd0, dtack_n}, 8'd1);
        for (int i = 0; i < 4; i++) begin
            drive_at_neg();
            wr_n = i[0]; cs_n = i[1];
            edge_then_sample();
        end
        chk("R4 sticky", {7'd0, style_rw}, 8'd1);
        drive_at_neg();
        cs_n = 1'b1; wr_n = 1'b1;
        vec_we = 1'b1; vec_wdata = 8'h3C;
        edge_then_sample();
        drive_at_neg();
        vec_we = 1'b0; iack_n = 1'b0;
        #1;
        chk("R8 written rw", vec_out, 8'h3C);
        do_reset();
        drive_at_neg();
        irq_en = 1'b1; iack_n = 1'b0;
        #1;
        chk("R10 cleared", vec_out, 8'h00);
        chk("R1 style after reset", {7'd0, style_rw}, 8'd0);
        iack_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset_state();
        t_irq();
        t_vec_gate_sep();
        t_vec_write_sep();
        t_lock_sep();
        t_rw_style();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule